// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits between a CPU bus and a small on-chip flash array model. It holds a control/status register and turns short unlock-style command write sequences on the array address space into timed embedded operations. A program changes one byte. An erase blanks any chosen combination of seven unequal sectors. A running erase can be suspended and later resumed.

While an operation runs, array reads return a status byte instead of array data. That byte carries a data-polling bit and a toggle bit. Completion raises the ready bit and sets a sticky flag. The flag drives the interrupt output when interrupts are enabled.

The array holds 256 allocation units of `UNIT_BYTES` bytes each. The seven sectors take 32, 1, 1, 14, 16, 64 and 128 units, in rising address order. With the default of 4 bytes per unit, the sectors start at byte 0, 128, 132, 136, 192, 256 and 512, and the array ends at 1024.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset the register reads 0x10 and every array byte reads 0xFF. The register layout is: bit 7 interrupt enable, bit 6 done flag, bit 5 command enable, bit 4 ready (read-only), bits 3..1 read 0, bit 0 low-power. Reads return data on `bus_rdata` one cycle after the request.
- R2: Array writes made while command enable (bit 5) is 0 are ignored. They start nothing and leave the array, the ready bit and the decoder unchanged.
- R3: The write bytes 0xAA, 0x55, 0xA0 followed by one write of (address, data) programs that byte. The stored value becomes old AND data, so a program can only clear bits.
- R4: Ready reads 0 from the cycle after a command is accepted until the operation ends. A program takes `PROG_CYC` cycles (default 8).
- R5: An array read during an active operation returns a status byte. Bit 7 is the complement of bit 7 of the target data; for an erase the target is 0xFF, so bit 7 is 0. Bit 6 starts at 0 and inverts on each status read. Bits 5..0 are 0.
- R6: On completion, ready returns to 1 and the done flag is set. The `irq` output is the done flag AND interrupt enable. Writing 0 to bit 6 clears the flag; writing 1 to bit 6 has no effect.
- R7: The sequence 0xAA, 0x55, 0x80, 0xAA, 0x55, then 0x30 written to an address selects that address's sector. Each further 0x30 written within `SEL_WIN` cycles of the previous one adds a sector. Every byte of each selected sector becomes 0xFF, and all other sectors keep their data.
- R8: Sector membership follows the unit map above. An erase reaches the first and last byte of its sector and stops at both neighbouring sectors.
- R9: An erase lasts `ERASE_CYC` cycles (default 64) per selected sector, plus the selection window.
- R10: Writing 0xB0 during a running erase suspends it. Ready stays 0, array reads return array data, and the erase counter is frozen. Writing 0x30 resumes the erase from the frozen count.
- R11: A byte that does not fit the current step of a sequence returns the decoder to idle without starting an operation.
- R12: Bit 0 of the register is plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus transfer request, one cycle per transfer |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_csr | input | 1 | 1 = control/status register, 0 = flash array |
| bus_addr | input | AW | Byte address in the array |
| bus_wdata | input | 8 | Write data or command byte |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest state to reach from the ports is a suspended erase that is partly done. The bench has to open the sector-selection window and let it close. It must then let the erase counter run for a known number of cycles before writing the suspend byte. Only after that can it show that reads return true array data and that the counter holds. The bench counts ready polls after the resume and checks that fewer cycles than a full sector erase remain. Sector-boundary bytes are programmed on both sides of an erased sector beforehand, so the same run also checks the sector map.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int NSECT = 7;
  localparam int TOTAL_UNITS = 256;

  localparam logic [7:0] CMD_UNLK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLK2 = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;

  typedef enum logic [2:0] {OP_IDLE, OP_PROG, OP_SEL, OP_ERASE, OP_SUSP} op_state_e;
  typedef enum logic [2:0] {D_IDLE, D_U1, D_U2, D_PRG, D_E1, D_E2, D_E3, D_SEL} dec_state_e;
  typedef enum logic [1:0] {RS_ARR, RS_CSR, RS_STAT} rd_src_e;

  // first allocation unit of each sector, in address order
  function automatic int sect_base_units(input int k);
    case (k)
      0: return 0;
      1: return 32;
      2: return 33;
      3: return 34;
      4: return 48;
      5: return 64;
      6: return 128;
      default: return TOTAL_UNITS;
    endcase
  endfunction

  function automatic logic [2:0] sect_of(input int byte_addr, input int unit);
    logic [2:0] r;
    r = 3'd0;
    for (int k = 1; k < NSECT; k++)
      if (byte_addr >= sect_base_units(k) * unit) r = 3'(k);
    return r;
  endfunction

  function automatic logic [2:0] lowest_sect(input logic [NSECT-1:0] m);
    logic [2:0] r;
    r = 3'd0;
    for (int k = NSECT-1; k >= 0; k--)
      if (m[k]) r = 3'(k);
    return r;
  endfunction
endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       prog_busy,
  input  logic       op_active,
  input  logic       erase_run,
  input  logic       erase_susp,
  input  logic       sel_open,
  output logic       go_prog,
  output logic       add_sect,
  output logic       suspend,
  output logic       resume,
  output dec_state_e state
);
  dec_state_e st_n;

  always_comb begin
    st_n     = state;
    go_prog  = 1'b0;
    add_sect = 1'b0;
    suspend  = 1'b0;
    resume   = 1'b0;
    if (wr_stb) begin
      case (state)
        D_IDLE: begin
          if (erase_run && wr_data == CMD_SUSP) suspend = 1'b1;
          else if (erase_susp && wr_data == CMD_SECT) resume = 1'b1;
          else if (wr_data == CMD_UNLK1 && !prog_busy) st_n = D_U1;
        end
        D_U1: st_n = (wr_data == CMD_UNLK2) ? D_U2 : D_IDLE;
        D_U2: begin
          if (!op_active && wr_data == CMD_PROG) st_n = D_PRG;
          else if (!op_active && wr_data == CMD_ERASE) st_n = D_E1;
          else st_n = D_IDLE;
        end
        D_PRG: begin
          go_prog = 1'b1;
          st_n    = D_IDLE;
        end
        D_E1: st_n = (wr_data == CMD_UNLK1) ? D_E2 : D_IDLE;
        D_E2: st_n = (wr_data == CMD_UNLK2) ? D_E3 : D_IDLE;
        D_E3: begin
          if (wr_data == CMD_SECT) begin
            add_sect = 1'b1;
            st_n     = D_SEL;
          end else st_n = D_IDLE;
        end
        D_SEL: begin
          if (wr_data == CMD_SECT && sel_open) add_sect = 1'b1;
          else st_n = D_IDLE;
        end
        default: st_n = D_IDLE;
      endcase
    end else if (state == D_SEL && !sel_open) begin
      st_n = D_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= D_IDLE;
    else     state <= st_n;
  end
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_seq_pkg::*;
#(
  parameter int UNIT  = 4,
  parameter int DEPTH = TOTAL_UNITS * UNIT,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    dout,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          erase_en,
  input  logic [2:0]    erase_idx
);
  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] blank;
  logic [7:0]       q;
  logic             blank_q;

  // data store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

  // per-byte erased marks let a whole sector blank in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      blank   <= '1;
      blank_q <= 1'b1;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (erase_en && sect_of(i, UNIT) == erase_idx) blank[i] <= 1'b1;
      if (we) blank[waddr] <= 1'b0;
      if (re) blank_q <= blank[raddr];
    end
  end

  assign dout = blank_q ? 8'hFF : q;
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int UNIT_BYTES = 4,
  parameter int PROG_CYC   = 8,
  parameter int ERASE_CYC  = 64,
  parameter int SEL_WIN    = 8,
  localparam int DEPTH     = TOTAL_UNITS * UNIT_BYTES,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic          bus_csr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq
);
  localparam int CMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int WW   = $clog2(SEL_WIN + 1);

  op_state_e        op_st;
  dec_state_e       dec_st;
  logic [CW-1:0]    cnt;
  logic [WW-1:0]    win;
  logic [NSECT-1:0] mask, mask_left;
  logic [2:0]       cur_sect;
  logic [AW-1:0]    tgt_addr;
  logic [7:0]       tgt_data, old_byte, csr_q, stat_q, arr_dout;
  logic             old_vld, ready_q, done_flag_q, irq_en_q, cmd_en_q, lowpwr_q, tog_q;
  rd_src_e          rsel_q;
  logic             go_prog, add_sect, suspend, resume;
  logic             rd_stb, arr_wr_stb, csr_wr_stb, status_mode, arr_re, arr_we, erase_en, finish;

  assign rd_stb      = bus_en && !bus_wr;
  assign arr_wr_stb  = bus_en && bus_wr && !bus_csr && cmd_en_q;
  assign csr_wr_stb  = bus_en && bus_wr && bus_csr;
  assign status_mode = (op_st == OP_PROG) || (op_st == OP_SEL) || (op_st == OP_ERASE);
  assign arr_re      = (rd_stb && !bus_csr && !status_mode) || go_prog;
  assign arr_we      = (op_st == OP_PROG) && (cnt == '0);
  assign erase_en    = (op_st == OP_ERASE) && (cnt == '0) && !suspend;
  assign mask_left   = mask & ~(NSECT'(1) << cur_sect);
  assign finish      = arr_we || (erase_en && mask_left == '0);

  flash_cmd_decoder dec_i (
    .clk, .rst,
    .wr_stb    (arr_wr_stb),
    .wr_data   (bus_wdata),
    .prog_busy (op_st == OP_PROG),
    .op_active (op_st != OP_IDLE),
    .erase_run (op_st == OP_ERASE),
    .erase_susp(op_st == OP_SUSP),
    .sel_open  (op_st == OP_SEL),
    .go_prog, .add_sect, .suspend, .resume,
    .state     (dec_st)
  );

  flash_array #(.UNIT(UNIT_BYTES), .DEPTH(DEPTH), .AW(AW)) arr_i (
    .clk, .rst,
    .re       (arr_re),
    .raddr    (bus_addr),
    .dout     (arr_dout),
    .we       (arr_we),
    .waddr    (tgt_addr),
    .wdata    (old_byte & tgt_data),
    .erase_en (erase_en),
    .erase_idx(cur_sect)
  );

  // embedded operation sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      op_st    <= OP_IDLE;
      cnt      <= '0;
      win      <= '0;
      mask     <= '0;
      cur_sect <= '0;
      tgt_addr <= '0;
      tgt_data <= 8'hFF;
      old_byte <= 8'hFF;
      old_vld  <= 1'b0;
      ready_q  <= 1'b1;
    end else begin
      case (op_st)
        OP_IDLE: begin
          if (go_prog) begin
            op_st    <= OP_PROG;
            cnt      <= CW'(PROG_CYC - 1);
            tgt_addr <= bus_addr;
            tgt_data <= bus_wdata;
            old_vld  <= 1'b0;
            ready_q  <= 1'b0;
          end else if (add_sect) begin
            op_st    <= OP_SEL;
            mask     <= NSECT'(1) << sect_of(int'(bus_addr), UNIT_BYTES);
            win      <= '0;
            tgt_data <= 8'hFF;
            ready_q  <= 1'b0;
          end
        end
        OP_PROG: begin
          if (!old_vld) begin
            old_byte <= arr_dout;
            old_vld  <= 1'b1;
          end
          if (cnt == '0) begin
            op_st   <= OP_IDLE;
            ready_q <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        OP_SEL: begin
          if (add_sect) begin
            mask <= mask | (NSECT'(1) << sect_of(int'(bus_addr), UNIT_BYTES));
            win  <= '0;
          end else if (win == WW'(SEL_WIN - 1)) begin
            op_st    <= OP_ERASE;
            cur_sect <= lowest_sect(mask);
            cnt      <= CW'(ERASE_CYC - 1);
          end else win <= win + 1'b1;
        end
        OP_ERASE: begin
          if (suspend) op_st <= OP_SUSP;
          else if (cnt == '0) begin
            mask <= mask_left;
            if (mask_left == '0) begin
              op_st   <= OP_IDLE;
              ready_q <= 1'b1;
            end else begin
              cur_sect <= lowest_sect(mask_left);
              cnt      <= CW'(ERASE_CYC - 1);
            end
          end else cnt <= cnt - 1'b1;
        end
        OP_SUSP: if (resume) op_st <= OP_ERASE;
        default: op_st <= OP_IDLE;
      endcase
    end
  end

  // control/status register and read path
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q    <= 1'b0;
      done_flag_q <= 1'b0;
      cmd_en_q    <= 1'b0;
      lowpwr_q    <= 1'b0;
      tog_q       <= 1'b0;
      rsel_q      <= RS_CSR;
      csr_q       <= 8'h10;
      stat_q      <= 8'h00;
    end else begin
      if (csr_wr_stb) begin
        irq_en_q <= bus_wdata[7];
        cmd_en_q <= bus_wdata[5];
        lowpwr_q <= bus_wdata[0];
        if (!bus_wdata[6]) done_flag_q <= 1'b0;
      end
      if (finish) done_flag_q <= 1'b1;
      if (go_prog || (op_st == OP_IDLE && add_sect)) tog_q <= 1'b0;
      if (rd_stb) begin
        if (bus_csr) begin
          rsel_q <= RS_CSR;
          csr_q  <= {irq_en_q, done_flag_q, cmd_en_q, ready_q, 3'b000, lowpwr_q};
        end else if (status_mode) begin
          rsel_q <= RS_STAT;
          stat_q <= {~tgt_data[7], tog_q, 6'b000000};
          tog_q  <= ~tog_q;
        end else rsel_q <= RS_ARR;
      end
    end
  end

  assign bus_rdata = (rsel_q == RS_ARR) ? arr_dout : (rsel_q == RS_CSR) ? csr_q : stat_q;
  assign irq       = irq_en_q && done_flag_q;
endmodule

// File: rtl/flash_seq_ctrl_chk.sv
module flash_seq_ctrl_chk
  import flash_seq_pkg::*;
#(
  parameter int CW = 7
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_en,
  input logic       bus_wr,
  input logic       bus_csr,
  input logic [7:0] bus_rdata,
  input logic       cmd_en_q,
  input logic       ready_q,
  input logic       done_flag_q,
  input logic       tog_q,
  input logic [CW-1:0] cnt,
  input op_state_e  op_st,
  input dec_state_e dec_st
);
  logic stat_rd;
  assign stat_rd = bus_en && !bus_wr && !bus_csr &&
                   (op_st == OP_PROG || op_st == OP_SEL || op_st == OP_ERASE);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (op_st != OP_IDLE) |-> !ready_q);  // R4
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> done_flag_q);  // R6
  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_wr && !bus_csr && !cmd_en_q && dec_st != D_SEL) |=> (dec_st == $past(dec_st)));  // R2
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (bus_rdata[5:0] == 6'd0));  // R5
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (tog_q != $past(tog_q)));  // R5
  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (op_st == OP_SUSP) |=> (op_st != OP_SUSP || $stable(cnt)));  // R10
endmodule

bind flash_seq_ctrl flash_seq_ctrl_chk #(.CW(CW)) chk_i (
  .clk, .rst, .bus_en, .bus_wr, .bus_csr, .bus_rdata,
  .cmd_en_q, .ready_q, .done_flag_q, .tog_q, .cnt, .op_st, .dec_st
);

// File: tb/flash_seq_ctrl_tb_top.sv
module flash_seq_ctrl_tb_top;
  localparam int PROG_CYC  = 8;
  localparam int ERASE_CYC = 64;
  localparam int SEL_WIN   = 8;
  localparam int AW        = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_en = 1'b0, bus_wr = 1'b0, bus_csr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          irq;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  flash_seq_ctrl #(.UNIT_BYTES(4), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SEL_WIN(SEL_WIN)) dut_i (
    .clk, .rst, .bus_en, .bus_wr, .bus_csr, .bus_addr, .bus_wdata, .bus_rdata, .irq
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      n_run  = n_run + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // vector: kind(0 write,1 read-check), csr, addr, data, expected, requirement
  localparam int NV = 14;
  localparam logic [32:0] VEC [NV] = '{
    {2'd1, 1'b1, 10'd0,    8'h00, 8'h10, 4'd1},   // R1 register reset value
    {2'd1, 1'b0, 10'd5,    8'h00, 8'hFF, 4'd1},   // R1 array blank
    {2'd1, 1'b0, 10'd1023, 8'h00, 8'hFF, 4'd1},   // R1 last byte blank
    {2'd0, 1'b1, 10'd0,    8'h01, 8'h00, 4'd12},
    {2'd1, 1'b1, 10'd0,    8'h00, 8'h11, 4'd12},  // R12 low-power bit stored
    {2'd0, 1'b1, 10'd0,    8'h00, 8'h00, 4'd12},
    {2'd0, 1'b0, 10'd0,    8'hAA, 8'h00, 4'd2},   // R2 locked writes
    {2'd0, 1'b0, 10'd0,    8'h55, 8'h00, 4'd2},
    {2'd0, 1'b0, 10'd0,    8'hA0, 8'h00, 4'd2},
    {2'd0, 1'b0, 10'd5,    8'h00, 8'h00, 4'd2},
    {2'd1, 1'b1, 10'd0,    8'h00, 8'h10, 4'd2},   // R2 still ready
    {2'd1, 1'b0, 10'd5,    8'h00, 8'hFF, 4'd2},   // R2 byte untouched
    {2'd0, 1'b1, 10'd0,    8'hA0, 8'h00, 4'd6},
    {2'd1, 1'b1, 10'd0,    8'h00, 8'hB0, 4'd6}    // R6 enable bits read back
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run = n_run + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic check_range(input string req, input int got, input int lo, input int hi);
    n_run = n_run + 1;
    if (got < lo || got > hi) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic csr, input logic [AW-1:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_csr = csr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic csr, input logic [AW-1:0] a, output logic [7:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_csr = csr; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
    wr(1'b0, 0, 8'hAA); wr(1'b0, 0, 8'h55); wr(1'b0, 0, 8'hA0); wr(1'b0, a, d);
  endtask

  task automatic erase_prefix();
    wr(1'b0, 0, 8'hAA); wr(1'b0, 0, 8'h55); wr(1'b0, 0, 8'h80);
    wr(1'b0, 0, 8'hAA); wr(1'b0, 0, 8'h55);
  endtask

  task automatic wait_ready(output int n);
    logic [7:0] v;
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(1'b1, 0, v);
      n = n + 1;
      if (v[4]) break;
    end
  endtask

  task automatic clear_flag();
    wr(1'b1, 0, 8'hA0);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32:31] == 2'd0) wr(VEC[i][30], VEC[i][29:20], VEC[i][19:12]);
      else begin
        rd(VEC[i][30], VEC[i][29:20], v);
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][11:4]);
      end
    end
    check("R6 irq low after reset", {7'd0, irq}, 8'h00);

    // program with status polling
    program_byte(10'd5, 8'h3C);
    rd(1'b1, 0, v); check("R4 ready drops", v & 8'h10, 8'h00);
    rd(1'b0, 10'd5, v); check("R5 status first read", v, 8'h80);
    rd(1'b0, 10'd5, v); check("R5 status toggled", v, 8'hC0);
    wait_ready(n);
    check_range("R4 program busy cycles", 2 + n, PROG_CYC, PROG_CYC + 1);
    rd(1'b1, 0, v); check("R6 done flag set", v, 8'hF0);
    check("R6 irq raised", {7'd0, irq}, 8'h01);
    rd(1'b0, 10'd5, v); check("R3 programmed byte", v, 8'h3C);
    wr(1'b1, 0, 8'hE0);
    rd(1'b1, 0, v); check("R6 writing 1 keeps flag", v, 8'hF0);
    clear_flag();
    rd(1'b1, 0, v); check("R6 flag cleared", v, 8'hB0);
    check("R6 irq cleared", {7'd0, irq}, 8'h00);

    // program only clears bits
    program_byte(10'd5, 8'hF0);
    wait_ready(n);
    rd(1'b0, 10'd5, v); check("R3 and-merge", v, 8'h30);
    clear_flag();

    // broken sequences
    wr(1'b0, 0, 8'hAA); wr(1'b0, 0, 8'h12); wr(1'b0, 0, 8'hA0); wr(1'b0, 10'd5, 8'h00);
    rd(1'b1, 0, v); check("R11 bad unlock starts nothing", v, 8'hB0);
    rd(1'b0, 10'd5, v); check("R11 byte unchanged", v, 8'h30);
    wr(1'b0, 0, 8'hAA); wr(1'b0, 0, 8'h55); wr(1'b0, 0, 8'h80); wr(1'b0, 0, 8'hAA);
    wr(1'b0, 0, 8'h11); wr(1'b0, 10'd5, 8'h30);
    rd(1'b1, 0, v); check("R11 bad erase prefix", v, 8'hB0);
    rd(1'b0, 10'd5, v); check("R11 no erase", v, 8'h30);

    // boundary bytes around sector 3 (bytes 136..191)
    program_byte(10'd135, 8'h35); wait_ready(n);
    program_byte(10'd136, 8'h36); wait_ready(n);
    program_byte(10'd191, 8'h91); wait_ready(n);
    program_byte(10'd192, 8'h92); wait_ready(n);
    program_byte(10'd600, 8'h66); wait_ready(n);
    clear_flag();

    // two-sector erase: sector 0 and sector 3
    erase_prefix();
    wr(1'b0, 10'd5, 8'h30);
    wr(1'b0, 10'd150, 8'h30);
    rd(1'b0, 10'd5, v); check("R5 erase status", v, 8'h00);
    wait_ready(n);
    check_range("R9 two-sector erase time", 1 + n, 2 * ERASE_CYC, 2 * ERASE_CYC + SEL_WIN + 3);
    rd(1'b0, 10'd5, v);   check("R7 sector 0 erased", v, 8'hFF);
    rd(1'b0, 10'd136, v); check("R8 sector 3 first byte", v, 8'hFF);
    rd(1'b0, 10'd191, v); check("R8 sector 3 last byte", v, 8'hFF);
    rd(1'b0, 10'd135, v); check("R8 sector 2 kept", v, 8'h35);
    rd(1'b0, 10'd192, v); check("R8 sector 4 kept", v, 8'h92);
    rd(1'b0, 10'd600, v); check("R7 sector 6 kept", v, 8'h66);
    rd(1'b1, 0, v);       check("R6 erase done flag", v, 8'hF0);
    clear_flag();

    // suspend and resume
    erase_prefix();
    wr(1'b0, 10'd600, 8'h30);
    repeat (SEL_WIN + 22) @(negedge clk);
    wr(1'b0, 0, 8'hB0);
    repeat (100) @(negedge clk);
    rd(1'b1, 0, v);       check("R10 ready low while suspended", v, 8'hA0);
    rd(1'b0, 10'd600, v); check("R10 array data while suspended", v, 8'h66);
    wr(1'b0, 0, 8'h30);
    wait_ready(n);
    check_range("R10 resume continues count", n, ERASE_CYC - 30, ERASE_CYC - 15);
    rd(1'b0, 10'd600, v); check("R10 erase completed", v, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule